// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a compact SPI master that a processor operates through a byte-wide register window. Software places an opcode in one register and the two transfer lengths in another: the low nibble is the payload length and the high nibble the read length. It then pushes up to eight payload bytes through a data port into an eight-slot buffer and sets a start bit. The engine lowers chip select and sends the opcode followed by the payload on SPI mode 0. It then clocks in the requested read bytes and returns chip select high.

Read bytes go into the same buffer, in the slots that follow the last payload byte. When the command ends, the buffer pointer returns to zero. Reading the data port then yields the payload bytes first and the received bytes after them. When no payload is sent, the read-length field is programmed one above the wanted count, and the engine clocks one byte fewer on the wire. This keeps the received data aligned for the same driver sequence. The serial clock is the system clock divided by the even parameter `CLK_DIV`.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the start bit (offset 0x2 bit 0) and busy bit (offset 0x3 bit 7) read 0, and the pointer (offset 0xD bits [2:0]) reads 0.
- R2: The opcode held at offset 0x0 is the first byte on the wire, sent MSB first. The payload bytes follow it, taken from buffer slots 0 onward in the order they were written. MOSI changes only while the clock is low.
- R3: Offset 0x1 holds the payload length in bits [3:0] and the read length in bits [7:4]. A payload length above 8 is treated as 8.
- R4: Writing 1 to offset 0x2 bit 0 while idle starts a command. That bit and offset 0x3 bit 7 both read 1 until the command ends, and both read 0 after it.
- R5: A start write made while a command runs is ignored: the running command keeps its byte count and no second frame follows.
- R6: Each read or write of the data port at offset 0xC while idle moves the pointer up by one, wrapping modulo 8. Writing 1 to offset 0x2 bit 4 sets the pointer to 0.
- R7: Read bytes are sampled on the rising serial clock edge, MSB first. Each is stored at the slot following the previous payload or read byte, modulo 8. At the end of a command the pointer is 0, so data-port reads return the payload and then the read bytes.
- R8: When the payload length is 0 and the read length field N is nonzero, only N-1 bytes are clocked in after the opcode. They are stored from slot 0.
- R9: Chip select falls CLK_DIV+CLK_DIV/2 system clocks before the first rising serial clock edge. It rises CLK_DIV system clocks after the last falling edge. The serial clock is high for CLK_DIV/2 clocks and low for CLK_DIV/2 clocks.
- R10: Data-port reads and writes made while a command runs are ignored. They change neither the buffer nor the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access (advances the pointer at the data port) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current offset, combinational |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A wrong pointer or slot index would surface as bytes in the wrong order or position. This shows on the MOSI stream within the same frame, or on the first data-port reads after the frame. A wrong byte count or length decode shows up as extra or missing serial clocks before chip select rises. A sequencing fault in the framing shows up in the measured gaps between chip select and the first or last clock edge. A start bit that fails to clear keeps the start and busy bits at 1, so the status poll never completes.

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int CLK_DIV = 4,
  parameter int DEPTH   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DIVW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int PW   = $clog2(DEPTH);
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(CLK_DIV - 1);
  localparam logic [DIVW-1:0] DIV_MID  = DIVW'(HALF - 1);
  localparam logic [DIVW-1:0] DIV_HI   = DIVW'(HALF);
  localparam logic [3:0]      MAX_TX   = 4'(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_TRAIL} state_t;

  state_t          state;
  logic [7:0]      opcode_q, count_q;
  logic [7:0]      fifo [DEPTH];
  logic [PW-1:0]   ptr;
  logic [DIVW-1:0] div;
  logic [2:0]      bit_cnt;
  logic [4:0]      bidx, total;
  logic [3:0]      txn;
  logic [7:0]      sh_tx, sh_rx;

  wire run      = (state != S_IDLE);
  wire div_end  = (div == DIV_LAST);
  wire byte_end = (state == S_SHIFT) && div_end && (bit_cnt == 3'd7);
  wire rx_byte  = (bidx > {1'b0, txn});
  wire [PW-1:0] rx_slot = PW'(bidx - 5'd1);

  wire wr_opc  = reg_wr && (reg_addr == 4'h0) && !run;
  wire wr_cnt  = reg_wr && (reg_addr == 4'h1) && !run;
  wire wr_ctl  = reg_wr && (reg_addr == 4'h2);
  wire start   = wr_ctl && reg_wdata[0] && !run;
  wire rewind  = wr_ctl && reg_wdata[4] && !run;
  wire port_wr = reg_wr && (reg_addr == 4'hC) && !run;
  wire port_rd = reg_rd && (reg_addr == 4'hC) && !run;

  wire [3:0] tx_req = (count_q[3:0] > MAX_TX) ? MAX_TX : count_q[3:0];
  wire [3:0] rx_req = ((count_q[3:0] == 4'd0) && (count_q[7:4] != 4'd0))
                      ? count_q[7:4] - 4'd1 : count_q[7:4];

  assign spi_cs_n = !run;
  assign spi_sck  = (state == S_SHIFT) && (div >= DIV_HI);
  assign spi_mosi = (state == S_SHIFT) && sh_tx[7];

  always_comb begin
    case (reg_addr)
      4'h0:    reg_rdata = opcode_q;
      4'h1:    reg_rdata = count_q;
      4'h2:    reg_rdata = {7'd0, run};
      4'h3:    reg_rdata = {run, 7'd0};
      4'hC:    reg_rdata = fifo[ptr];
      4'hD:    reg_rdata = 8'(ptr);
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q <= 8'h00;
      count_q  <= 8'h00;
    end else begin
      if (wr_opc) opcode_q <= reg_wdata;
      if (wr_cnt) count_q  <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      div     <= '0;
      bit_cnt <= 3'd0;
      bidx    <= 5'd0;
      total   <= 5'd0;
      txn     <= 4'd0;
      sh_tx   <= 8'h00;
      sh_rx   <= 8'h00;
    end else begin
      if (run) div <= div_end ? '0 : div + 1'b1;
      case (state)
        S_IDLE: if (start) begin
          state   <= S_LEAD;
          div     <= '0;
          bit_cnt <= 3'd0;
          bidx    <= 5'd0;
          txn     <= tx_req;
          total   <= 5'd1 + {1'b0, tx_req} + {1'b0, rx_req};
          sh_tx   <= opcode_q;
        end
        S_LEAD: if (div_end) state <= S_SHIFT;
        S_SHIFT: begin
          if (div == DIV_MID) sh_rx <= {sh_rx[6:0], spi_miso};
          if (div_end) begin
            if (bit_cnt == 3'd7) begin
              bit_cnt <= 3'd0;
              if (bidx == total - 5'd1) state <= S_TRAIL;
              else begin
                bidx  <= bidx + 5'd1;
                sh_tx <= ((bidx + 5'd1) <= {1'b0, txn}) ? fifo[PW'(bidx)] : 8'h00;
              end
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              sh_tx   <= {sh_tx[6:0], 1'b0};
            end
          end
        end
        S_TRAIL: if (div_end) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) fifo[i] <= 8'h00;
    end else begin
      if (byte_end && rx_byte) fifo[rx_slot] <= sh_rx;
      if (port_wr) fifo[ptr] <= reg_wdata;
      if (rewind || ((state == S_TRAIL) && div_end)) ptr <= '0;
      else if (port_wr || port_rd) ptr <= ptr + 1'b1;
    end
  end

  a_r9_cs_frames_clock: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  a_r3_tx_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (txn <= MAX_TX));

  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (run && state != S_LEAD && wr_ctl && reg_wdata[0]) |=> (state != S_LEAD));

  a_r6_rewind_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (ptr == '0));

  a_r7_ptr_home: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> (ptr == '0));

  a_r10_port_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(ptr));
endmodule

// File: tb/spi_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb;
  localparam int CLK_DIV = 4;
  localparam int HALF = CLK_DIV / 2;

  logic clk = 0, rst_n = 0;
  logic [3:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso;

  always #2.5 clk = ~clk;

  spi_cmd_engine #(.CLK_DIV(CLK_DIV), .DEPTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso));

  int n_tests = 0, n_fail = 0;
  int bc = 0, nbytes = 0;
  logic [7:0] mshift = 0;
  logic [7:0] mbytes [32];
  realtime t_csfall, t_first, t_lastfall, t_csrise;
  logic [7:0] pay [8];

  function automatic logic [7:0] resp(input int j);
    return 8'(j * 53 + 91);
  endfunction

  assign spi_miso = !spi_cs_n && resp(bc / 8)[7 - (bc % 8)];

  always @(negedge spi_cs_n or posedge spi_sck) begin
    if (spi_sck) begin
      if (bc == 0) t_first = $realtime;
      mshift = {mshift[6:0], spi_mosi};
      if (bc % 8 == 7 && bc / 8 < 32) mbytes[bc / 8] = mshift;
      bc = bc + 1;
    end else begin
      bc = 0;
      t_csfall = $realtime;
    end
  end
  always @(negedge spi_sck) t_lastfall = $realtime;
  always @(posedge spi_cs_n) begin
    t_csrise = $realtime;
    nbytes = bc / 8;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_done();
    logic [7:0] v;
    v = 8'h01;
    for (int i = 0; i < 2000 && v[0]; i++) rd(4'h2, v);
    chk("R4 start bit clears", v[0], 0);
    rd(4'h3, v);
    chk("R4 busy clears", v[7], 0);
  endtask

  task automatic load(input logic [7:0] op, input logic [7:0] cnt, input int np);
    wr(4'h2, 8'h10);
    for (int i = 0; i < np; i++) wr(4'hC, pay[i]);
    wr(4'h1, cnt);
    wr(4'h0, op);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 cs_n high", spi_cs_n, 1);
    chk("R1 sck low", spi_sck, 0);
    rd(4'h2, v); chk("R1 start bit", v[0], 0);
    rd(4'h3, v); chk("R1 busy bit", v[7], 0);
    rd(4'hD, v); chk("R1 pointer", v, 0);
  endtask

  task automatic t_pointer();
    logic [7:0] v;
    for (int i = 0; i < 3; i++) wr(4'hC, 8'h40 + 8'(i));
    rd(4'hD, v); chk("R6 pointer after 3 writes", v, 3);
    wr(4'h2, 8'h10);
    rd(4'hD, v); chk("R6 rewind", v, 0);
    rd(4'hC, v); chk("R6 slot0 data", v, 8'h40);
    rd(4'hD, v); chk("R6 read advances", v, 1);
    wr(4'h2, 8'h10);
    for (int i = 0; i < 9; i++) wr(4'hC, 8'h00);
    rd(4'hD, v); chk("R6 wrap modulo 8", v, 1);
  endtask

  task automatic t_txrx();
    logic [7:0] v;
    pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'hC3;
    load(8'h9F, 8'h23, 3);
    wr(4'h2, 8'h01);
    rd(4'h2, v); chk("R4 start bit reads 1", v[0], 1);
    rd(4'h3, v); chk("R4 busy reads 1", v[7], 1);
    wr(4'h2, 8'h01);
    wr(4'hC, 8'hEE);
    rd(4'hD, v); chk("R10 pointer frozen while busy", v, 3);
    wait_done();
    chk("R5 byte count unchanged", nbytes, 6);
    chk("R2 opcode first", mbytes[0], 8'h9F);
    for (int i = 0; i < 3; i++) chk("R2 payload order", mbytes[1 + i], pay[i]);
    chk("R9 cs lead", int'((t_first - t_csfall) / 5.0), CLK_DIV + HALF);
    chk("R9 cs trail", int'((t_csrise - t_lastfall) / 5.0), CLK_DIV);
    rd(4'hD, v); chk("R7 pointer home", v, 0);
    for (int i = 0; i < 3; i++) begin
      rd(4'hC, v); chk("R7 R10 payload readback", v, pay[i]);
    end
    rd(4'hC, v); chk("R7 rx byte 0", v, resp(4));
    rd(4'hC, v); chk("R7 rx byte 1", v, resp(5));
    repeat (20) @(negedge clk);
    chk("R5 no second frame", spi_cs_n, 1);
  endtask

  task automatic t_offby1();
    logic [7:0] v;
    load(8'h03, 8'h30, 0);
    wr(4'h2, 8'h01);
    wait_done();
    chk("R8 wire bytes", nbytes, 3);
    rd(4'hC, v); chk("R8 slot0", v, resp(1));
    rd(4'hC, v); chk("R8 slot1", v, resp(2));
  endtask

  task automatic t_clamp();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) pay[i] = 8'h80 + 8'(i * 7);
    load(8'h02, 8'h1C, 8);
    wr(4'h2, 8'h01);
    wait_done();
    chk("R3 clamped wire bytes", nbytes, 10);
    for (int i = 0; i < 8; i++) chk("R3 R2 payload", mbytes[1 + i], pay[i]);
    rd(4'hC, v); chk("R7 rx wraps to slot0", v, resp(9));
    rd(4'hC, v); chk("R7 slot1 kept", v, pay[1]);
  endtask

  task automatic t_opcode_only();
    load(8'h06, 8'h00, 0);
    wr(4'h2, 8'h01);
    wait_done();
    chk("R8 opcode-only bytes", nbytes, 1);
    chk("R2 opcode-only value", mbytes[0], 8'h06);
  endtask

  initial begin
    #(200000 * 5.0);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pointer();
    t_txrx();
    t_offby1();
    t_clamp();
    t_opcode_only();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule